// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the command front end of a parallel NOR flash, modelled as synchronous logic. It watches single-cycle bus write strobes, each carrying an address and a data word, and matches them against multi-write command sequences. It keeps track of the access mode (array read, identification, query table, fast-program bypass, and an extended-block overlay) and issues one-cycle start requests to a separate program/erase engine. It also selects what a bus read returns: array data, identification words, block protection bits, query-table data or the engine status word.

Only the low data byte takes part in decoding. The array, the engine, the query table and the status word are outside the block and reach it as plain input ports. Protection is a per-block bit vector indexed by the upper address bits. A program or erase request aimed at a protected block is dropped without any indication.

Top module: `nfc_cmd_dec`

## Requirements
- R1: After reset the block is in array-read mode with the overlay off. Reads return `array_rdata`, `ext_sel` is low and no start or suspend pulse is issued.
- R2: Unlock cycles are low byte 0xAA at word address 0x555, then 0x55 at 0x2AA, then a command byte at 0x555. Only `addr[10:0]` is compared. A write that does not fit the sequence in progress drops it, and decoding restarts from array-read idle.
- R3: Command 0x90 enters identification mode. The read word depends on `addr[1:0]`: 00 gives 0x0020, 01 gives 0x22C7, 10 gives the protection bit of the block `addr[21:12]` (0x0001 or 0x0000), and 11 gives 0x0000.
- R4: In identification mode, only a single 0xF0 write (which returns to array read) and the query entry are acted on. Every other write, including a full program sequence, changes nothing.
- R5: A single write of 0x98 at word address 0x055 enters query mode from array-read idle or from identification mode. Reads then return `cfi_rdata`, and 0xF0 returns to whichever of those two modes was active before.
- R6: Command 0xA0 arms a program. The next write starts it: `go_prog` is high for the one cycle after that strobe, with `op_addr` and the full 16-bit `op_data` taken from it.
- R7: Command 0x80, then 0xAA@0x555, then 0x55@0x2AA, then 0x10@0x555 pulses `go_chip_erase`. Ending the same sequence with 0x30 at any address instead pulses `go_blk_erase`, with `op_addr` set to that address.
- R8: A program or block erase whose address falls in a block whose `blk_prot` bit is set produces no pulse.
- R9: Command 0x20 enters bypass mode. In bypass mode 0xA0 followed by one write starts a program, 0x90 followed by 0x00 returns to array read, and 0xF0 does not leave the mode. Reads return array data.
- R10: Command 0x88 turns the extended-block overlay on. `ext_sel` is then high whenever `addr[21:12]` equals the boot block (block 0). The unlock cycles followed by 0x90 and then 0x00 turn the overlay off; any other fourth write leaves it on.
- R11: While `eng_busy` is high, reads return `status_rdata` and every write is ignored, except that 0xB0 pulses `go_suspend` when the most recent start was a block erase.
- R12: Data bits 15..8 have no effect on command decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | Bus write strobe, one cycle per write |
| addr | input | 22 | Word address for reads and writes |
| wdata | input | 16 | Write data |
| eng_busy | input | 1 | Program/erase engine is running |
| blk_prot | input | 1024 | Protection bit per block |
| array_rdata | input | 16 | Array read data |
| status_rdata | input | 16 | Engine status word |
| cfi_rdata | input | 16 | Query-table read data |
| rdata | output | 16 | Selected read data |
| ext_sel | output | 1 | Current access is steered to the extended block |
| go_prog | output | 1 | Program start pulse |
| go_chip_erase | output | 1 | Chip erase start pulse |
| go_blk_erase | output | 1 | Block erase start pulse |
| go_suspend | output | 1 | Erase suspend request pulse |
| op_addr | output | 22 | Target address of the last start |
| op_data | output | 16 | Program data of the last start |

## Verification
The hardest situations to reach are the command bytes that no directed test would think of at the third unlock position, and the nesting where query mode must return to identification mode rather than to array read. The bench sweeps all 256 values of the third write. After each one it appends two fixed probe writes and reads the pulse counters, the identification word and the overlay flag, so that every byte is classified by an arithmetic rule. A second sweep reads the protection word of all 1024 blocks against a computed pattern. The nested exits and the busy-time suspend filter are driven by short directed sequences.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {MD_READ, MD_AUTO, MD_CFI, MD_BYP} mode_e;
  typedef enum logic [3:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_XEXIT, SQ_E1, SQ_E2, SQ_E3, SQ_BPGM, SQ_BEXIT
  } seq_e;

  localparam logic [7:0] CB_UNLK1 = 8'hAA;
  localparam logic [7:0] CB_UNLK2 = 8'h55;
  localparam logic [7:0] CB_IDENT = 8'h90;
  localparam logic [7:0] CB_PROG  = 8'hA0;
  localparam logic [7:0] CB_ERSU  = 8'h80;
  localparam logic [7:0] CB_BYP   = 8'h20;
  localparam logic [7:0] CB_RST   = 8'hF0;
  localparam logic [7:0] CB_QRY   = 8'h98;
  localparam logic [7:0] CB_EXT   = 8'h88;
  localparam logic [7:0] CB_CHIP  = 8'h10;
  localparam logic [7:0] CB_BLK   = 8'h30;
  localparam logic [7:0] CB_SUSP  = 8'hB0;
  localparam logic [7:0] CB_ZERO  = 8'h00;

  localparam logic [10:0] UA_FIRST  = 11'h555;
  localparam logic [10:0] UA_SECOND = 11'h2AA;
  localparam logic [10:0] UA_QUERY  = 11'h055;
endpackage

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int BW = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_stb,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              eng_busy,
  input  logic [(1<<BW)-1:0] blk_prot,
  output mode_e             mode_o,
  output logic              ext_on_o,
  output logic              go_prog,
  output logic              go_cerase,
  output logic              go_berase,
  output logic              go_susp,
  output logic [AW-1:0]     op_addr,
  output logic [DW-1:0]     op_data
);
  mode_e mode_q, mode_d, ret_q, ret_d;
  seq_e  seq_q, seq_d;
  logic  ext_q, ext_d, blkop_q, blkop_d;
  logic  prog_d, cer_d, ber_d, sus_d, ld_op;
  logic [7:0]  cb;
  logic [10:0] ua;
  logic        tgt_prot;

  assign cb       = wdata[7:0];
  assign ua       = addr[10:0];
  assign tgt_prot = blk_prot[addr[AW-1 -: BW]];

  always_comb begin
    mode_d  = mode_q;
    ret_d   = ret_q;
    seq_d   = seq_q;
    ext_d   = ext_q;
    blkop_d = blkop_q;
    prog_d  = 1'b0;
    cer_d   = 1'b0;
    ber_d   = 1'b0;
    sus_d   = 1'b0;
    if (wr_stb) begin
      if (eng_busy) begin
        sus_d = (cb == CB_SUSP) && blkop_q;
      end else begin
        case (mode_q)
          MD_CFI: if (cb == CB_RST) mode_d = ret_q;
          MD_AUTO: begin
            if (cb == CB_RST) mode_d = MD_READ;
            else if (cb == CB_QRY && ua == UA_QUERY) begin
              mode_d = MD_CFI;
              ret_d  = MD_AUTO;
            end
          end
          MD_BYP: begin
            case (seq_q)
              SQ_BPGM: begin
                seq_d   = SQ_IDLE;
                prog_d  = !tgt_prot;
                blkop_d = tgt_prot ? blkop_q : 1'b0;
              end
              SQ_BEXIT: begin
                seq_d = SQ_IDLE;
                if (cb == CB_ZERO) mode_d = MD_READ;
              end
              default: begin
                if (cb == CB_PROG) seq_d = SQ_BPGM;
                else if (cb == CB_IDENT) seq_d = SQ_BEXIT;
              end
            endcase
          end
          default: begin
            seq_d = SQ_IDLE;
            case (seq_q)
              SQ_IDLE: begin
                if (cb == CB_UNLK1 && ua == UA_FIRST) seq_d = SQ_U1;
                else if (cb == CB_QRY && ua == UA_QUERY) begin
                  mode_d = MD_CFI;
                  ret_d  = MD_READ;
                end
              end
              SQ_U1: if (cb == CB_UNLK2 && ua == UA_SECOND) seq_d = SQ_U2;
              SQ_U2: begin
                if (ua == UA_FIRST) begin
                  case (cb)
                    CB_IDENT: if (ext_q) seq_d = SQ_XEXIT; else mode_d = MD_AUTO;
                    CB_PROG:  seq_d = SQ_PGM;
                    CB_ERSU:  seq_d = SQ_E1;
                    CB_BYP:   mode_d = MD_BYP;
                    CB_EXT:   ext_d = 1'b1;
                    default:  ;
                  endcase
                end
              end
              SQ_PGM: begin
                prog_d  = !tgt_prot;
                blkop_d = tgt_prot ? blkop_q : 1'b0;
              end
              SQ_XEXIT: if (cb == CB_ZERO) ext_d = 1'b0;
              SQ_E1: if (cb == CB_UNLK1 && ua == UA_FIRST) seq_d = SQ_E2;
              SQ_E2: if (cb == CB_UNLK2 && ua == UA_SECOND) seq_d = SQ_E3;
              SQ_E3: begin
                if (cb == CB_CHIP && ua == UA_FIRST) begin
                  cer_d   = 1'b1;
                  blkop_d = 1'b0;
                end else if (cb == CB_BLK && !tgt_prot) begin
                  ber_d   = 1'b1;
                  blkop_d = 1'b1;
                end
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  assign ld_op = prog_d | ber_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MD_READ;
      ret_q     <= MD_READ;
      seq_q     <= SQ_IDLE;
      ext_q     <= 1'b0;
      blkop_q   <= 1'b0;
      go_prog   <= 1'b0;
      go_cerase <= 1'b0;
      go_berase <= 1'b0;
      go_susp   <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
    end else begin
      mode_q    <= mode_d;
      ret_q     <= ret_d;
      seq_q     <= seq_d;
      ext_q     <= ext_d;
      blkop_q   <= blkop_d;
      go_prog   <= prog_d;
      go_cerase <= cer_d;
      go_berase <= ber_d;
      go_susp   <= sus_d;
      if (ld_op) begin
        op_addr <= addr;
        op_data <= wdata;
      end
    end
  end

  assign mode_o   = mode_q;
  assign ext_on_o = ext_q;

  // R6 R7
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({go_prog, go_cerase, go_berase}));
  // R11
  busy_nostart_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (go_prog || go_cerase || go_berase) |-> !$past(eng_busy));
  // R11
  susp_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    go_susp |-> $past(eng_busy));
  // R4
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == MD_AUTO && !wr_stb) |=> mode_q == MD_AUTO);
  // R9
  byp_rst_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == MD_BYP && wr_stb && wdata[7:0] == CB_RST) |=> mode_q == MD_BYP);
  // R5
  cfi_leave_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == MD_CFI && wr_stb && !eng_busy && wdata[7:0] == CB_RST) |=> mode_q != MD_CFI);
endmodule

// File: rtl/nfc_rdmux.sv
module nfc_rdmux
  import nfc_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          BW       = 10,
  parameter logic [15:0] MFR_ID   = 16'h0020,
  parameter logic [15:0] DEV_ID   = 16'h22C7,
  parameter int          BOOT_BLK = 0
) (
  input  mode_e              mode,
  input  logic               eng_busy,
  input  logic               ext_on,
  input  logic [BW-1:0]      blk,
  input  logic [1:0]         sel,
  input  logic [(1<<BW)-1:0] blk_prot,
  input  logic [DW-1:0]      array_rdata,
  input  logic [DW-1:0]      status_rdata,
  input  logic [DW-1:0]      cfi_rdata,
  output logic [DW-1:0]      rdata,
  output logic               ext_sel
);
  localparam logic [BW-1:0] BOOT = BW'(BOOT_BLK);
  logic [DW-1:0] id_word;

  always_comb begin
    case (sel)
      2'b00:   id_word = DW'(MFR_ID);
      2'b01:   id_word = DW'(DEV_ID);
      2'b10:   id_word = DW'(blk_prot[blk]);
      default: id_word = '0;
    endcase
  end

  always_comb begin
    if (eng_busy)                rdata = status_rdata;
    else if (mode == MD_AUTO)    rdata = id_word;
    else if (mode == MD_CFI)     rdata = cfi_rdata;
    else                         rdata = array_rdata;
  end

  assign ext_sel = ext_on && (blk == BOOT);
endmodule

// File: rtl/nfc_cmd_dec.sv
module nfc_cmd_dec
  import nfc_pkg::*;
#(
  parameter int          AW       = 22,
  parameter int          DW       = 16,
  parameter int          BW       = 10,
  parameter logic [15:0] MFR_ID   = 16'h0020,
  parameter logic [15:0] DEV_ID   = 16'h22C7,
  parameter int          BOOT_BLK = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic               eng_busy,
  input  logic [(1<<BW)-1:0] blk_prot,
  input  logic [DW-1:0]      array_rdata,
  input  logic [DW-1:0]      status_rdata,
  input  logic [DW-1:0]      cfi_rdata,
  output logic [DW-1:0]      rdata,
  output logic               ext_sel,
  output logic               go_prog,
  output logic               go_chip_erase,
  output logic               go_blk_erase,
  output logic               go_suspend,
  output logic [AW-1:0]      op_addr,
  output logic [DW-1:0]      op_data
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  mode_e      mode;
  logic       ext_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  nfc_seq #(.AW(AW), .DW(DW), .BW(BW)) u_seq (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .wr_stb   (wr_stb),
    .addr     (addr),
    .wdata    (wdata),
    .eng_busy (eng_busy),
    .blk_prot (blk_prot),
    .mode_o   (mode),
    .ext_on_o (ext_on),
    .go_prog  (go_prog),
    .go_cerase(go_chip_erase),
    .go_berase(go_blk_erase),
    .go_susp  (go_suspend),
    .op_addr  (op_addr),
    .op_data  (op_data)
  );

  nfc_rdmux #(.DW(DW), .BW(BW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .BOOT_BLK(BOOT_BLK)) u_mux (
    .mode        (mode),
    .eng_busy    (eng_busy),
    .ext_on      (ext_on),
    .blk         (addr[AW-1 -: BW]),
    .sel         (addr[1:0]),
    .blk_prot    (blk_prot),
    .array_rdata (array_rdata),
    .status_rdata(status_rdata),
    .cfi_rdata   (cfi_rdata),
    .rdata       (rdata),
    .ext_sel     (ext_sel)
  );
endmodule

// File: tb/nfc_cmd_dec_test.sv
module nfc_cmd_dec_test;
  localparam logic [15:0] ARR = 16'hBEEF;
  localparam logic [15:0] STS = 16'h5A5A;
  localparam logic [15:0] QRY = 16'hC0F1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        eng_busy = 1'b0;
  logic [1023:0] blk_prot;
  logic [15:0] rdata, op_data;
  logic [21:0] op_addr;
  logic        ext_sel, go_prog, go_chip_erase, go_blk_erase, go_suspend;

  int total = 0, bad = 0, cyc = 0;
  int np = 0, nce = 0, nbe = 0, nsus = 0;
  logic [15:0] pd;
  logic [21:0] pa;

  always #5 clk = ~clk;

  initial for (int i = 0; i < 1024; i++) blk_prot[i] = (i % 7 == 3);

  nfc_cmd_dec uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
    .eng_busy(eng_busy), .blk_prot(blk_prot), .array_rdata(ARR),
    .status_rdata(STS), .cfi_rdata(QRY), .rdata(rdata), .ext_sel(ext_sel),
    .go_prog(go_prog), .go_chip_erase(go_chip_erase), .go_blk_erase(go_blk_erase),
    .go_suspend(go_suspend), .op_addr(op_addr), .op_data(op_data)
  );

  always @(negedge clk) begin
    cyc++;
    if (go_prog) begin np++; pd = op_data; pa = op_addr; end
    if (go_chip_erase) nce++;
    if (go_blk_erase) begin nbe++; pa = op_addr; end
    if (go_suspend) nsus++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk); #1;
  endtask

  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0; #1;
  endtask

  task automatic rd(input logic [21:0] a);
    addr = a; #1;
  endtask

  task automatic unlock(input logic [7:0] c);
    wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); wr(22'h555, {8'h00, c});
  endtask

  initial begin
    int n0, c0, b0, s0;
    logic [15:0] exp_rd;
    do_reset();
    // R1 reset state
    rd(22'h0);
    chk("R1 rdata", rdata, ARR);
    chk("R1 ext_sel", ext_sel, 0);
    chk("R1 pulses", {go_prog, go_chip_erase, go_blk_erase, go_suspend}, 0);

    // third-write sweep: R2 R3 R6 R9 R10
    for (int b = 0; b < 256; b++) begin
      do_reset();
      n0 = np; c0 = nce; b0 = nbe;
      unlock(b[7:0]);
      wr(22'h400, 16'h00A0);
      wr(22'h800, 16'h5678);
      rd(22'h0);
      exp_rd = (b == 8'h90) ? 16'h0020 : ARR;
      chk($sformatf("R3 sweep rd b=%02h", b), rdata, exp_rd);
      chk($sformatf("R10 sweep ext b=%02h", b), ext_sel, (b == 8'h88));
      chk($sformatf("R6 sweep np b=%02h", b), np - n0, (b == 8'hA0 || b == 8'h20) ? 1 : 0);
      chk($sformatf("R2 sweep erase b=%02h", b), (nce - c0) + (nbe - b0), 0);
      if (b == 8'hA0) chk("R6 sweep data", {pa[15:0], pd}, {16'h0400, 16'h00A0});
      if (b == 8'h20) chk("R9 sweep data", {pa[15:0], pd}, {16'h0800, 16'h5678});
    end

    // R3 identification words and protection sweep
    do_reset();
    unlock(8'h90);
    rd(22'h0); chk("R3 mfr", rdata, 16'h0020);
    rd(22'h1); chk("R3 dev", rdata, 16'h22C7);
    rd(22'h3); chk("R3 sel11", rdata, 16'h0000);
    for (int i = 0; i < 1024; i++) begin
      rd({i[9:0], 12'h002});
      chk($sformatf("R3 prot blk=%0d", i), rdata, (i % 7 == 3) ? 1 : 0);
    end

    // R4 identification ignores program, R5 query nesting
    n0 = np;
    unlock(8'hA0); wr(22'h400, 16'h1234);
    rd(22'h0);
    chk("R4 no prog", np - n0, 0);
    chk("R4 still ident", rdata, 16'h0020);
    wr(22'h055, 16'h0098); rd(22'h0); chk("R5 query from ident", rdata, QRY);
    wr(22'h0, 16'h00F0);   rd(22'h0); chk("R5 back to ident", rdata, 16'h0020);
    wr(22'h0, 16'h00F0);   rd(22'h0); chk("R4 reset to read", rdata, ARR);
    wr(22'h055, 16'h0098); rd(22'h0); chk("R5 query from read", rdata, QRY);
    wr(22'h0, 16'h00F0);   rd(22'h0); chk("R5 back to read", rdata, ARR);

    // R2 broken sequences
    wr(22'h555, 16'h00AA); wr(22'h123, 16'h0055); wr(22'h555, 16'h0090);
    rd(22'h0); chk("R2 bad addr 2nd", rdata, ARR);
    wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); wr(22'h554, 16'h0090);
    rd(22'h0); chk("R2 bad addr 3rd", rdata, ARR);

    // R7 erase, R8 protection
    c0 = nce; b0 = nbe; n0 = np;
    unlock(8'h80); unlock(8'h10);
    chk("R7 chip", nce - c0, 1);
    unlock(8'h80); wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); wr(22'h5000, 16'h0030);
    chk("R7 blk", nbe - b0, 1);
    chk("R7 blk addr", pa, 22'h5000);
    unlock(8'h80); wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); wr(22'h3000, 16'h0030);
    chk("R8 prot blk erase", nbe - b0, 1);
    unlock(8'hA0); wr(22'h3010, 16'h4444);
    chk("R8 prot prog", np - n0, 0);

    // R11 busy behaviour
    s0 = nsus;
    unlock(8'h80); wr(22'h555, 16'h00AA); wr(22'h2AA, 16'h0055); wr(22'h6000, 16'h0030);
    @(negedge clk); eng_busy = 1'b1; #1;
    rd(22'h0); chk("R11 status", rdata, STS);
    unlock(8'h90);
    wr(22'h0, 16'h00B0);
    chk("R11 suspend", nsus - s0, 1);
    @(negedge clk); eng_busy = 1'b0; #1;
    rd(22'h0); chk("R11 ignored ident", rdata, ARR);
    unlock(8'h80); unlock(8'h10);
    @(negedge clk); eng_busy = 1'b1; #1;
    wr(22'h0, 16'h00B0);
    chk("R11 no suspend on chip", nsus - s0, 1);
    @(negedge clk); eng_busy = 1'b0; #1;

    // R9 bypass
    do_reset();
    n0 = np;
    unlock(8'h20);
    wr(22'h0, 16'h00F0);
    wr(22'h0, 16'h00A0); wr(22'h1000, 16'h1111);
    chk("R9 prog after F0", np - n0, 1);
    chk("R9 data", pd, 16'h1111);
    rd(22'h0); chk("R9 reads array", rdata, ARR);
    wr(22'h0, 16'h0090); wr(22'h0, 16'h0000);
    wr(22'h0, 16'h00A0); wr(22'h1000, 16'h2222);
    chk("R9 exit", np - n0, 1);

    // R10 extended overlay
    do_reset();
    unlock(8'h88);
    rd(22'h00123); chk("R10 boot steered", ext_sel, 1);
    rd(22'h01000); chk("R10 other block", ext_sel, 0);
    unlock(8'h90); wr(22'h0, 16'h0001);
    rd(22'h0); chk("R10 bad exit keeps", ext_sel, 1);
    unlock(8'h90); wr(22'h0, 16'h0000);
    rd(22'h0); chk("R10 exit", ext_sel, 0);

    // R12 upper bits ignored
    do_reset();
    wr(22'h555, 16'hFFAA); wr(22'h2AA, 16'h3355); wr(22'h555, 16'h8090);
    rd(22'h0); chk("R12 upper bits", rdata, 16'h0020);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule